// File: doc/BRIEF.md
# Memory low-power pin sequencer

This block drives the six low-power control pins of an embedded memory macro: light sleep, high-speed, input gating, standby, sleep and array power-switch off. For each pin, an 8-entry behaviour mask is indexed by a 3-bit power-level input, and the selected bit gives the value the pin should reach. A software mode can bypass the masks and use one override bit per pin instead. Each pin has its own counter. A pin moves to a new value only after a programmable 16-bit delay: one delay applies when it rises and another when it falls.

Configuration and status are reached through a plain single-cycle register port. A write completes on the clock edge where `reg_wr_i` is high. Reads are combinational from `reg_addr_i`. The port has no back-pressure, because every access completes at once. A sticky lock bit freezes the delay settings until the next reset. A control bit selects whether the memory's power-ready input is passed on to the slice power status or is masked out.

Top module: `mem_lp_seq`

## Requirements
- R1: After reset all six pins are 0, every delay register reads 0, and the control register reads 0 (software mode off, lock clear).
- R2: With control bit 0 clear, the target of pin i is bit `pwr_lvl_i` of that pin's 8-bit mask (mask register bits 7:0). Pin bit order in `lp_pins_o` is 0 light sleep, 1 high-speed, 2 input gating, 3 standby, 4 sleep, 5 array switch off.
- R3: With control bit 0 set, the target of pin i is bit 16 of its mask register, and the masks have no effect.
- R4: A pin whose target changes from 0 to 1 rises on the (D+1)-th clock edge, where D is its rise delay (delay register bits 15:0). Edges are counted from the first edge on which the new target is presented.
- R5: A pin whose target changes from 1 to 0 falls on the (D+1)-th edge, where D is its fall delay (delay register bits 31:16).
- R6: A delay of 0 makes the pin follow its target on the next clock edge.
- R7: If the target returns to the pin's present value before the count ends, the pin does not change and the count is discarded. A later change then counts its full delay from the beginning.
- R8: Control bit 20 is a lock. A write can set it but cannot clear it; only reset clears it. While it is set, writes to the delay registers have no effect.
- R9: The status register (address 1) reads the power level in bits 2:0 and the live pin values in bits 8:3, in the R2 pin order.
- R10: `slice_mem_ok_o` equals `mem_pwr_ok_i` when control bit 1 is 0, and is 1 when control bit 1 is 1.
- R11: On pin 5 (array switch off), the rise delay is the wait before the switch turns off and the fall delay is the wait before it turns back on.
- R12: The address map is: 0 control, 1 status (read-only), 2+i mask register of pin i, 8+i delay register of pin i. Written fields read back unchanged, and all other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_lvl_i | input | 3 | Current power level |
| mem_pwr_ok_i | input | 1 | Memory power-ready status |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| lp_pins_o | output | 6 | Low-power pin values |
| slice_mem_ok_o | output | 1 | Memory status forwarded to the slice |

## Verification
The power level is swept through masks that differ per pin. This separates the per-pin lookup from a shared one and catches a wrong index bit. Software mode is then run with masks that disagree with the override bits, so any leak from the masks shows up. Rise and fall counts are measured with distinct, unequal delays, including zero. This detects swapped delay halves and off-by-one counting. A target pulse shorter than the delay tells a counter that restarts apart from one that resumes.

// File: rtl/mlp_pkg.sv
package mlp_pkg;
  localparam int NUM_PINS  = 6;
  localparam int LVL_W     = 3;
  localparam int NUM_LVL   = 1 << LVL_W;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 32;
  localparam int DLY_W     = 16;
  localparam int A_CTRL    = 0;
  localparam int A_STAT    = 1;
  localparam int A_MASK0   = 2;
  localparam int A_DLY0    = A_MASK0 + NUM_PINS;
  localparam int B_SWMODE  = 0;
  localparam int B_EXCL    = 1;
  localparam int B_LOCK    = 20;
  localparam int B_SWPIN   = 16;
  localparam int B_STPINS  = LVL_W;
endpackage

// File: rtl/mlp_regs.sv
module mlp_regs
  import mlp_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [DATA_W-1:0]                 rdata_o,
  input  logic [LVL_W-1:0]                  lvl_i,
  input  logic [NUM_PINS-1:0]               pins_i,
  output logic                              swmode_o,
  output logic                              excl_o,
  output logic [NUM_PINS-1:0][NUM_LVL-1:0]  mask_o,
  output logic [NUM_PINS-1:0]               swpin_o,
  output logic [NUM_PINS-1:0][DLY_W-1:0]    dly_hi_o,
  output logic [NUM_PINS-1:0][DLY_W-1:0]    dly_lo_o
);
  logic lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swmode_o <= 1'b0;
      excl_o   <= 1'b0;
      lock_q   <= 1'b0;
      mask_o   <= '0;
      swpin_o  <= '0;
      dly_hi_o <= '0;
      dly_lo_o <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_W'(A_CTRL)) begin
        swmode_o <= wdata_i[B_SWMODE];
        excl_o   <= wdata_i[B_EXCL];
        lock_q   <= lock_q | wdata_i[B_LOCK];
      end
      for (int i = 0; i < NUM_PINS; i++) begin
        if (addr_i == ADDR_W'(A_MASK0 + i)) begin
          mask_o[i]  <= wdata_i[NUM_LVL-1:0];
          swpin_o[i] <= wdata_i[B_SWPIN];
        end
        if (addr_i == ADDR_W'(A_DLY0 + i) && !lock_q) begin
          dly_hi_o[i] <= wdata_i[DLY_W-1:0];
          dly_lo_o[i] <= wdata_i[2*DLY_W-1:DLY_W];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_CTRL)) begin
      rdata_o[B_SWMODE] = swmode_o;
      rdata_o[B_EXCL]   = excl_o;
      rdata_o[B_LOCK]   = lock_q;
    end
    if (addr_i == ADDR_W'(A_STAT)) begin
      rdata_o[LVL_W-1:0]                 = lvl_i;
      rdata_o[B_STPINS+NUM_PINS-1:B_STPINS] = pins_i;
    end
    for (int i = 0; i < NUM_PINS; i++) begin
      if (addr_i == ADDR_W'(A_MASK0 + i)) begin
        rdata_o[NUM_LVL-1:0] = mask_o[i];
        rdata_o[B_SWPIN]     = swpin_o[i];
      end
      if (addr_i == ADDR_W'(A_DLY0 + i)) begin
        rdata_o = {dly_lo_o[i], dly_hi_o[i]};
      end
    end
  end

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  assert_delay_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(dly_hi_o) && $stable(dly_lo_o)));
endmodule

// File: rtl/mlp_pin_timer.sv
module mlp_pin_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tgt_i,
  input  logic [DLY_W-1:0] dly_hi_i,
  input  logic [DLY_W-1:0] dly_lo_i,
  output logic             pin_o
);
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] need;

  assign need = tgt_i ? dly_hi_i : dly_lo_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_o <= 1'b0;
      cnt_q <= '0;
    end else if (tgt_i == pin_o) begin
      cnt_q <= '0;
    end else if (cnt_q >= need) begin
      pin_o <= tgt_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_hold_counting_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_i != pin_o && cnt_q < need) |=> $stable(pin_o));
  assert_zero_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_i != pin_o && need == '0) |=> (pin_o == $past(tgt_i)));
  assert_idle_when_met_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_i == pin_o) |=> $stable(pin_o));
endmodule

// File: rtl/mem_lp_seq.sv
module mem_lp_seq
  import mlp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LVL_W-1:0]      pwr_lvl_i,
  input  logic                  mem_pwr_ok_i,
  input  logic                  reg_wr_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic [NUM_PINS-1:0]   lp_pins_o,
  output logic                  slice_mem_ok_o
);
  logic                             swmode, excl;
  logic [NUM_PINS-1:0][NUM_LVL-1:0] mask;
  logic [NUM_PINS-1:0]              swpin, tgt;
  logic [NUM_PINS-1:0][DLY_W-1:0]   dly_hi, dly_lo;

  mlp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .lvl_i(pwr_lvl_i),
    .pins_i(lp_pins_o), .swmode_o(swmode), .excl_o(excl), .mask_o(mask),
    .swpin_o(swpin), .dly_hi_o(dly_hi), .dly_lo_o(dly_lo)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign tgt[g] = swmode ? swpin[g] : mask[g][pwr_lvl_i];
    mlp_pin_timer #(.DLY_W(DLY_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tgt_i(tgt[g]),
      .dly_hi_i(dly_hi[g]), .dly_lo_i(dly_lo[g]), .pin_o(lp_pins_o[g])
    );
  end

  assign slice_mem_ok_o = excl | mem_pwr_ok_i;
endmodule

// File: tb/mem_lp_seq_tb.sv
`timescale 1ns/1ps
module mem_lp_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  lvl = '0;
  logic        mok = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  pins;
  logic        slice;
  int checks = 0, fails = 0, cyc = 0;

  int m_mask[6], m_sw[6], m_hi[6], m_lo[6], m_out[6], m_cnt[6];
  int m_swmode = 0, m_excl = 0, m_lock = 0;

  mem_lp_seq dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_lvl_i(lvl), .mem_pwr_ok_i(mok),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .lp_pins_o(pins), .slice_mem_ok_o(slice)
  );

  always #2 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference, updated at each edge from pre-edge settings
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) begin
        m_mask[i] = 0; m_sw[i] = 0; m_hi[i] = 0; m_lo[i] = 0;
        m_out[i] = 0; m_cnt[i] = 0;
      end
      m_swmode = 0; m_excl = 0; m_lock = 0;
    end else begin
      for (int i = 0; i < 6; i++) begin
        int t, d;
        t = m_swmode ? m_sw[i] : ((m_mask[i] >> lvl) & 1);
        if (t == m_out[i]) m_cnt[i] = 0;
        else begin
          d = t ? m_hi[i] : m_lo[i];
          if (m_cnt[i] >= d) begin m_out[i] = t; m_cnt[i] = 0; end
          else m_cnt[i]++;
        end
      end
      if (wr) begin
        if (addr == 0) begin
          m_swmode = wdata[0]; m_excl = wdata[1];
          if (wdata[20]) m_lock = 1;
        end
        for (int i = 0; i < 6; i++) begin
          if (addr == 2 + i) begin m_mask[i] = wdata[7:0]; m_sw[i] = wdata[16]; end
          if (addr == 8 + i && !m_lock) begin m_hi[i] = wdata[15:0]; m_lo[i] = wdata[31:16]; end
        end
      end
    end
  end

  // per-cycle comparison of pins (R2..R7) and slice status (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      logic [5:0] ep;
      for (int i = 0; i < 6; i++) ep[i] = m_out[i][0];
      chk("R2 model pins", {26'b0, pins}, {26'b0, ep});
      chk("R10 model slice", {31'b0, slice}, {31'b0, (m_excl != 0) | mok});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wreg(int a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(int a, output logic [31:0] d);
    @(negedge clk); addr = 4'(a); #1; d = rdata;
  endtask

  task automatic measure(int pin, logic val, output int n);
    n = 0;
    while (pins[pin] !== val && n < 200) begin
      @(posedge clk); n++; @(negedge clk); #0.5;
    end
  endtask

  initial begin
    logic [31:0] r;
    int n;
    repeat (3) @(negedge clk);
    chk("R1 pins after reset", {26'b0, pins}, 32'h0);
    rst_n = 1'b1;
    rreg(0, r);  chk("R1 ctrl reset", r, 32'h0);
    rreg(8, r);  chk("R1 delay reset", r, 32'h0);
    rreg(13, r); chk("R1 delay reset pin5", r, 32'h0);

    wreg(2, 32'h0001_00A5); rreg(2, r); chk("R12 mask readback", r, 32'h0001_00A5);
    wreg(9, 32'h0003_0002); rreg(9, r); chk("R12 delay readback", r, 32'h0003_0002);
    rreg(15, r); chk("R12 unused address", r, 32'h0);
    wreg(9, 32'h0);

    // R2 / R6: distinct masks per pin, zero delays
    for (int i = 0; i < 6; i++) wreg(2 + i, 32'(8'h1 << (i + 1)) | 32'h80);
    for (int l = 0; l < 8; l++) begin
      @(negedge clk); lvl = 3'(l);
      @(posedge clk); @(negedge clk); #0.5;
      for (int i = 0; i < 6; i++)
        chk("R6 R2 lookup", {31'b0, pins[i]}, {31'b0, (l == i + 1) || (l == 7)});
    end

    // R9 status
    @(negedge clk); lvl = 3'd7; repeat (2) @(negedge clk);
    rreg(1, r); chk("R9 status", r, {23'b0, 6'h3F, 3'd7});

    // R4 / R5: unequal delays on pin 0
    @(negedge clk); lvl = 3'd0; repeat (2) @(negedge clk);
    wreg(2, 32'h0000_0002); wreg(8, 32'h0002_0004);
    @(negedge clk); lvl = 3'd1; measure(0, 1'b1, n); chk("R4 rise edges", n, 5);
    @(negedge clk); lvl = 3'd0; measure(0, 1'b0, n); chk("R5 fall edges", n, 3);

    // R7: short pulse then restart
    wreg(8, 32'h0000_0005);
    @(negedge clk); lvl = 3'd1;
    repeat (3) @(negedge clk);
    lvl = 3'd0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #0.5; chk("R7 no glitch", {31'b0, pins[0]}, 32'h0);
    end
    lvl = 3'd1; measure(0, 1'b1, n); chk("R7 restart full count", n, 6);

    // R11: array switch pin 5
    @(negedge clk); lvl = 3'd0; repeat (2) @(negedge clk);
    wreg(7, 32'h0000_0004); wreg(13, 32'h0001_0003);
    @(negedge clk); lvl = 3'd2; measure(5, 1'b1, n); chk("R11 switch-off wait", n, 4);
    @(negedge clk); lvl = 3'd0; measure(5, 1'b0, n); chk("R11 switch-on wait", n, 2);

    // R3: software mode overrides masks
    for (int i = 0; i < 6; i++) wreg(2 + i, (i % 2 == 0) ? 32'h0001_0000 : 32'h0000_00FF);
    wreg(8, 32'h0); wreg(13, 32'h0);
    wreg(0, 32'h1);
    repeat (3) @(negedge clk); #0.5;
    chk("R3 override pins", {26'b0, pins}, 32'h15);
    @(negedge clk); lvl = 3'd5; repeat (2) @(negedge clk); #0.5;
    chk("R3 level ignored", {26'b0, pins}, 32'h15);

    // R10
    wreg(0, 32'h0); @(negedge clk); mok = 1'b0; #0.5; chk("R10 pass low", {31'b0, slice}, 0);
    mok = 1'b1; #0.5; chk("R10 pass high", {31'b0, slice}, 1);
    wreg(0, 32'h2); @(negedge clk); mok = 1'b0; #0.5; chk("R10 excluded", {31'b0, slice}, 1);

    // R8: lock
    wreg(10, 32'h0007_0006);
    wreg(0, 32'h0010_0000);
    wreg(10, 32'hFFFF_FFFF); rreg(10, r); chk("R8 delay frozen", r, 32'h0007_0006);
    wreg(0, 32'h0); rreg(0, r); chk("R8 lock sticky", r, 32'h0010_0000);
    wreg(3, 32'h0000_00AA); rreg(3, r); chk("R8 masks still writable", r, 32'h0000_00AA);

    repeat (20) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule